// File: doc/BRIEF.md
# CEC Message Buffer Controller

This block stores messages for one node on a consumer-electronics-control bus. It sits between a byte-wide host register port and the serial bit engines. The host loads an outgoing message and its length into a transmit buffer, then starts or cancels the transfer by writing a command code. The block hands the message byte by byte to the transmit engine with a valid/ready handshake and waits for the engine's final result.

Incoming frames arrive from the receive engine one byte at a time and are closed by an end strobe. Good frames are kept in a two-slot queue. The host reads the oldest frame through a read-only window and retires it with a receive command code.

Each direction reports a two-bit status and a message count in registers. Addresses that the requirements do not name read back as zero.

Top module: `cec_msg_store`

## Requirements
- R1: After reset, transmit status (0x93), transmit count (0x94), receive status (0x91) and receive count (0x92) all read 0, and `tx_valid` is low. Status codes are: 0 idle, 1 busy, 2 done, 3 error.
- R2: Transmit bytes 0..15 are written and read back at 0x00..0x0F, and the length is written and read back at 0x10. While transmit status is busy, writes to these addresses are ignored.
- R3: Writing 1 or 3 to 0x11 with a length from 1 to 16 makes transmit status 1 and count 1. The block then presents bytes 0..length-1 in order on `tx_data`. Each byte is held until `tx_ready`, and `tx_last` marks the final byte.
- R4: Writing 1 or 3 to 0x11 with a length of 0 or above 16 sets transmit status 3 and count 0, and sends no byte.
- R5: Once the last byte has been accepted, a `tx_res_valid` pulse sets transmit status to 2 with count 0 if `tx_res_err` is low. If `tx_res_err` is high it sets status 3 and the count stays 1.
- R6: Writing 1 or 3 to 0x11 while transmit status is busy has no effect, and the status stays 1.
- R7: Writing 2 to 0x11 aborts the transfer. From the next cycle `tx_valid` is low, transmit status is 0 and the count is 0.
- R8: Any write to 0x13 sets every transmit byte, the length, the status and the count to 0.
- R9: Receive status reads 1 while a frame is arriving. When a good frame of 1 to 16 bytes ends, the count rises by one and status becomes 2. The oldest stored frame reads at 0x80..0x8F, and its length reads at 0x90. Both read 0 when no frame is stored.
- R10: Stored frames are kept in arrival order. Writing 3 to 0x14 removes the oldest frame and sets receive status to 0.
- R11: A frame is dropped and receive status becomes 3 in any of these cases: it ends while two frames are stored, it ends with `rx_err` high, or it carries more than 16 bytes. In each case the receive count is unchanged.
- R12: Writing 2 to 0x14 disables reception, so frames are ignored and status and count do not change. Writing 1 to 0x14 re-enables reception and sets status 0.
- R13: Any write to 0x15 empties the receive queue: count 0, status 0, 0x90 reads 0, and reception is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address for both read and write |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| tx_valid | output | 1 | A transmit byte is presented |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Presented byte is the final one of the message |
| tx_ready | input | 1 | Transmit engine accepts the presented byte |
| tx_res_valid | input | 1 | Transmit engine reports the message outcome |
| tx_res_err | input | 1 | Outcome was an error (qualified by `tx_res_valid`) |
| rx_valid | input | 1 | Receive engine delivers a byte |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | Current received frame has ended |
| rx_err | input | 1 | Frame ended in error (qualified by `rx_end`) |

## Verification
The assertions check on every cycle that a presented transmit byte holds steady until it is accepted and that `tx_valid` only appears with busy status. They also check that an abort clears the stream in one cycle, that a busy transfer ignores new start commands, that results map to the right status, and that the receive queue never exceeds or leaves its full level without a host command. Only the bench scenarios can show byte order and content on both sides, length validation, the effect of the clear registers, and FIFO ordering across pops. The same holds for the disable and re-enable sequence, which needs whole frames observed through the register window.

// File: rtl/cec_msg_pkg.sv
// Shared encodings for the CEC message buffer controller.
// Assumes an 8-bit host address space; the address map is fixed.
package cec_msg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2,
        ST_ERR  = 2'd3
    } xfer_st_e;

    localparam logic [7:0] CMD_NOP  = 8'd0;
    localparam logic [7:0] CMD_SEND = 8'd1;
    localparam logic [7:0] CMD_DROP = 8'd2;
    localparam logic [7:0] CMD_NEXT = 8'd3;

    localparam logic [7:0] A_TX_LEN = 8'h10;
    localparam logic [7:0] A_TX_CMD = 8'h11;
    localparam logic [7:0] A_TX_CLR = 8'h13;
    localparam logic [7:0] A_RX_CMD = 8'h14;
    localparam logic [7:0] A_RX_CLR = 8'h15;
    localparam logic [7:0] A_RX_LEN = 8'h90;
    localparam logic [7:0] A_RX_ST  = 8'h91;
    localparam logic [7:0] A_RX_CNT = 8'h92;
    localparam logic [7:0] A_TX_ST  = 8'h93;
    localparam logic [7:0] A_TX_CNT = 8'h94;
endpackage

// File: rtl/cec_tx_store.sv
// Transmit message store: one message buffer, length check, command
// handling and a byte stream towards the transmit engine.
// Assumes the engine answers with a single result pulse after the last byte.
module cec_tx_store
    import cec_msg_pkg::*;
#(
    parameter int MSG_BYTES = 16,
    localparam int IW = $clog2(MSG_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_byte,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_len,
    input  logic          cmd_we,
    input  logic          clr,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_byte,
    output logic [7:0]    len_o,
    output xfer_st_e      st_o,
    output logic          pend_o,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    input  logic          tx_res_valid,
    input  logic          tx_res_err
);
    logic [7:0]    buf_q [MSG_BYTES];
    logic [7:0]    len_q;
    xfer_st_e      st_q;
    logic          sending_q;
    logic          pend_q;
    logic [IW-1:0] idx_q;

    logic busy, len_ok, start, abort;
    assign busy   = (st_q == ST_BUSY);
    assign len_ok = (len_q != 8'd0) && (len_q <= 8'(MSG_BYTES));
    assign abort  = cmd_we && (wdata == CMD_DROP);
    assign start  = cmd_we && ((wdata == CMD_SEND) || (wdata == CMD_NEXT)) && !busy;

    // Buffer, length, status and streaming state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < MSG_BYTES; i++) buf_q[i] <= 8'd0;
            len_q     <= 8'd0;
            st_q      <= ST_IDLE;
            sending_q <= 1'b0;
            pend_q    <= 1'b0;
            idx_q     <= '0;
        end else begin
            if (wr_byte && !busy) buf_q[wr_idx] <= wdata;
            if (wr_len && !busy)  len_q <= wdata;
            if (abort) begin
                st_q      <= ST_IDLE;
                sending_q <= 1'b0;
                pend_q    <= 1'b0;
            end else if (start) begin
                if (len_ok) begin
                    st_q      <= ST_BUSY;
                    sending_q <= 1'b1;
                    pend_q    <= 1'b1;
                    idx_q     <= '0;
                end else begin
                    st_q   <= ST_ERR;
                    pend_q <= 1'b0;
                end
            end else begin
                if (sending_q && tx_ready) begin
                    if (tx_last) sending_q <= 1'b0;
                    else         idx_q <= idx_q + IW'(1);
                end
                if (busy && !sending_q && tx_res_valid) begin
                    st_q   <= tx_res_err ? ST_ERR : ST_DONE;
                    pend_q <= tx_res_err;
                end
            end
        end
    end

    // Outputs towards host and engine.
    assign tx_valid = sending_q;
    assign tx_data  = buf_q[idx_q];
    assign tx_last  = sending_q && ((8'(idx_q) + 8'd1) == len_q);
    assign rd_byte  = buf_q[rd_idx];
    assign len_o    = len_q;
    assign st_o     = st_q;
    assign pend_o   = pend_q;
endmodule

// File: rtl/cec_rx_store.sv
// Receive message store: a queue of SLOTS frame buffers filled from the
// receive engine and retired by host commands.
// Assumes rx_valid and rx_end never coincide; an end wins if they do.
module cec_rx_store
    import cec_msg_pkg::*;
#(
    parameter int MSG_BYTES = 16,
    parameter int SLOTS     = 2,
    localparam int IW = $clog2(MSG_BYTES),
    localparam int FW = $clog2(MSG_BYTES + 2),
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CW = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic          clr,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_byte,
    output logic [7:0]    len_o,
    output xfer_st_e      st_o,
    output logic [CW-1:0] cnt_o,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_end,
    input  logic          rx_err
);
    logic [7:0]    mem_q  [SLOTS][MSG_BYTES];
    logic [FW-1:0] lens_q [SLOTS];
    logic [SW-1:0] head_q, tail_q;
    logic [CW-1:0] cnt_q;
    logic [FW-1:0] fill_q;
    xfer_st_e      st_q;
    logic          en_q;

    logic full, end_evt, byte_evt, commit, pop, disable_c;

    function automatic logic [SW-1:0] nxt(input logic [SW-1:0] p);
        return (p == SW'(SLOTS - 1)) ? '0 : p + SW'(1);
    endfunction

    // Event decode for engine side and host commands.
    always_comb begin
        full      = (cnt_q == CW'(SLOTS));
        disable_c = cmd_we && (wdata == CMD_DROP);
        end_evt   = en_q && rx_end;
        byte_evt  = en_q && rx_valid && !rx_end;
        commit    = end_evt && !rx_err && !full && (fill_q != '0)
                    && (fill_q <= FW'(MSG_BYTES));
        pop       = cmd_we && (wdata == CMD_NEXT) && (cnt_q != '0);
    end

    // Queue pointers, fill index, status and enable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            fill_q <= '0;
            st_q   <= ST_IDLE;
            en_q   <= 1'b1;
            for (int s = 0; s < SLOTS; s++) lens_q[s] <= '0;
        end else if (disable_c) begin
            en_q   <= 1'b0;
            fill_q <= '0;
            st_q   <= ST_IDLE;
        end else begin
            if (end_evt) begin
                st_q   <= commit ? ST_DONE : ST_ERR;
                fill_q <= '0;
            end else if (byte_evt) begin
                st_q <= ST_BUSY;
                if (fill_q <= FW'(MSG_BYTES)) fill_q <= fill_q + FW'(1);
            end else if (cmd_we && ((wdata == CMD_SEND) || (wdata == CMD_NEXT))
                         && (st_q != ST_BUSY)) begin
                st_q <= ST_IDLE;
            end
            if (cmd_we && (wdata == CMD_SEND)) en_q <= 1'b1;
            if (commit) begin
                lens_q[tail_q] <= fill_q;
                tail_q         <= nxt(tail_q);
            end
            if (pop) head_q <= nxt(head_q);
            cnt_q <= cnt_q + CW'(commit) - CW'(pop);
        end
    end

    // Byte storage; no reset needed since reads are gated by the count.
    always_ff @(posedge clk) begin
        if (byte_evt && !disable_c && !full && (fill_q < FW'(MSG_BYTES)))
            mem_q[tail_q][fill_q[IW-1:0]] <= rx_data;
    end

    assign rd_byte = (cnt_q == '0) ? 8'd0 : mem_q[head_q][rd_idx];
    assign len_o   = (cnt_q == '0) ? 8'd0 : 8'(lens_q[head_q]);
    assign st_o    = st_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/cec_msg_store.sv
// Top of the CEC message buffer controller: host register decode, read
// mux, and the transmit and receive stores.
// Assumes MSG_BYTES is 16 so each byte window spans one address nibble.
module cec_msg_store
    import cec_msg_pkg::*;
#(
    parameter int MSG_BYTES = 16,
    parameter int RX_SLOTS  = 2,
    localparam int IW = $clog2(MSG_BYTES),
    localparam int CW = $clog2(RX_SLOTS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_last,
    input  logic       tx_ready,
    input  logic       tx_res_valid,
    input  logic       tx_res_err,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_end,
    input  logic       rx_err
);
    logic          in_tx_win, in_rx_win;
    logic [7:0]    tx_rd, tx_len, rx_rd, rx_len;
    xfer_st_e      tx_st, rx_st;
    logic          tx_pend;
    logic [CW-1:0] rx_cnt;

    assign in_tx_win = (reg_addr[7:4] == 4'h0);
    assign in_rx_win = (reg_addr[7:4] == 4'h8);

    cec_tx_store #(.MSG_BYTES(MSG_BYTES)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .wr_byte(reg_we && in_tx_win), .wr_idx(reg_addr[IW-1:0]),
        .wr_len(reg_we && (reg_addr == A_TX_LEN)),
        .cmd_we(reg_we && (reg_addr == A_TX_CMD)),
        .clr(reg_we && (reg_addr == A_TX_CLR)),
        .wdata(reg_wdata), .rd_idx(reg_addr[IW-1:0]),
        .rd_byte(tx_rd), .len_o(tx_len), .st_o(tx_st), .pend_o(tx_pend),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_res_valid(tx_res_valid), .tx_res_err(tx_res_err)
    );

    cec_rx_store #(.MSG_BYTES(MSG_BYTES), .SLOTS(RX_SLOTS)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(reg_we && (reg_addr == A_RX_CMD)),
        .clr(reg_we && (reg_addr == A_RX_CLR)),
        .wdata(reg_wdata), .rd_idx(reg_addr[IW-1:0]),
        .rd_byte(rx_rd), .len_o(rx_len), .st_o(rx_st), .cnt_o(rx_cnt),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end), .rx_err(rx_err)
    );

    // Host read mux.
    always_comb begin
        reg_rdata = 8'd0;
        if (in_tx_win)      reg_rdata = tx_rd;
        else if (in_rx_win) reg_rdata = rx_rd;
        else begin
            case (reg_addr)
                A_TX_LEN: reg_rdata = tx_len;
                A_RX_LEN: reg_rdata = rx_len;
                A_RX_ST:  reg_rdata = {6'd0, rx_st};
                A_RX_CNT: reg_rdata = 8'(rx_cnt);
                A_TX_ST:  reg_rdata = {6'd0, tx_st};
                A_TX_CNT: reg_rdata = {7'd0, tx_pend};
                default:  reg_rdata = 8'd0;
            endcase
        end
    end
endmodule

// File: rtl/cec_msg_store_chk.sv
// Property checker for cec_msg_store, bound to every instance of it.
// Watches host writes, the engine handshakes and the internal status.
module cec_msg_store_chk #(
    parameter int RX_SLOTS = 2,
    localparam int CW = $clog2(RX_SLOTS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    reg_addr,
    input logic          reg_we,
    input logic [7:0]    reg_wdata,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          tx_ready,
    input logic          tx_res_valid,
    input logic          tx_res_err,
    input logic [1:0]    tx_st,
    input logic [CW-1:0] rx_cnt
);
    logic tx_ctl_wr, rx_ctl_wr;
    assign tx_ctl_wr = reg_we && ((reg_addr == 8'h11) || (reg_addr == 8'h13));
    assign rx_ctl_wr = reg_we && ((reg_addr == 8'h14) || (reg_addr == 8'h15));

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !tx_ctl_wr) |=> (tx_valid && $stable(tx_data)));

    // R3
    tx_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_st == 2'd1));

    // R7
    tx_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == 8'h11) && (reg_wdata == 8'd2)) |=> (!tx_valid && (tx_st == 2'd0)));

    // R5
    tx_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_st == 2'd1) && !tx_valid && tx_res_valid && !tx_ctl_wr)
        |=> (tx_st == ($past(tx_res_err) ? 2'd3 : 2'd2)));

    // R6
    tx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_st == 2'd1) && reg_we && (reg_addr == 8'h11)
         && ((reg_wdata == 8'd1) || (reg_wdata == 8'd3)) && !tx_res_valid)
        |=> (tx_st == 2'd1));

    // R11
    rx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(RX_SLOTS));

    // R11
    rx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_cnt == CW'(RX_SLOTS)) && !rx_ctl_wr) |=> (rx_cnt == CW'(RX_SLOTS)));
endmodule

bind cec_msg_store cec_msg_store_chk #(.RX_SLOTS(RX_SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_res_valid(tx_res_valid), .tx_res_err(tx_res_err),
    .tx_st(tx_st), .rx_cnt(rx_cnt)
);

// File: tb/cec_msg_store_bench.sv
// Directed bench for cec_msg_store: one task per scenario.
module cec_msg_store_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       tx_valid, tx_last;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0, tx_res_valid = 1'b0, tx_res_err = 1'b0;
    logic       rx_valid = 1'b0, rx_end = 1'b0, rx_err = 1'b0;
    logic [7:0] rx_data = 8'd0;
    int         n_tests = 0;
    int         n_fail = 0;
    logic [7:0] exp_tx [16];

    always #2.5 clk = ~clk;

    cec_msg_store u_cec_msg_store (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_res_valid(tx_res_valid), .tx_res_err(tx_res_err),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end), .rx_err(rx_err)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #0.5;
        chk(req, reg_rdata, exp);
    endtask

    // Accept n bytes from the transmit side and compare with exp_tx.
    task automatic tx_collect(input string req, input int n);
        @(negedge clk);
        tx_ready = 1'b1;
        for (int k = 0; k < n; k++) begin
            #0.5;
            chk({req, " valid"}, {7'd0, tx_valid}, 8'd1);
            chk({req, " data"}, tx_data, exp_tx[k]);
            chk({req, " last"}, {7'd0, tx_last}, (k == n - 1) ? 8'd1 : 8'd0);
            @(negedge clk);
        end
        tx_ready = 1'b0;
        #0.5;
        chk({req, " valid after last"}, {7'd0, tx_valid}, 8'd0);
    endtask

    task automatic tx_result(input logic err);
        @(negedge clk);
        tx_res_valid = 1'b1; tx_res_err = err;
        @(negedge clk);
        tx_res_valid = 1'b0; tx_res_err = 1'b0;
    endtask

    // Deliver n bytes base, base+1, ... then an end strobe.
    task automatic rx_frame(input int n, input logic [7:0] base, input logic err,
                            input logic chk_busy);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = base + 8'(k);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        if (chk_busy) rd_chk("R9 rx busy mid-frame", 8'h91, 8'd1);
        rx_end = 1'b1; rx_err = err;
        @(negedge clk);
        rx_end = 1'b0; rx_err = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 tx status", 8'h93, 8'd0);
        rd_chk("R1 tx count", 8'h94, 8'd0);
        rd_chk("R1 rx status", 8'h91, 8'd0);
        rd_chk("R1 rx count", 8'h92, 8'd0);
        chk("R1 tx_valid", {7'd0, tx_valid}, 8'd0);
    endtask

    task automatic t_tx_regs;
        for (int i = 0; i < 4; i++) begin
            exp_tx[i] = 8'hA1 + 8'(i * 17);
            wr(8'(i), exp_tx[i]);
        end
        wr(8'h10, 8'd4);
        for (int i = 0; i < 4; i++) rd_chk("R2 tx byte readback", 8'(i), exp_tx[i]);
        rd_chk("R2 length readback", 8'h10, 8'd4);
    endtask

    task automatic t_tx_send_ok;
        wr(8'h11, 8'd1);
        rd_chk("R3 status busy", 8'h93, 8'd1);
        rd_chk("R3 count one", 8'h94, 8'd1);
        wr(8'h00, 8'h55);
        rd_chk("R2 write ignored while busy", 8'h00, exp_tx[0]);
        tx_collect("R3 stream", 4);
        wr(8'h11, 8'd3);
        rd_chk("R6 start ignored while busy", 8'h93, 8'd1);
        chk("R6 no restart", {7'd0, tx_valid}, 8'd0);
        tx_result(1'b0);
        rd_chk("R5 status done", 8'h93, 8'd2);
        rd_chk("R5 count cleared", 8'h94, 8'd0);
    endtask

    task automatic t_tx_send_err;
        wr(8'h11, 8'd3);
        rd_chk("R3 code 3 starts", 8'h93, 8'd1);
        tx_collect("R3 stream code 3", 4);
        tx_result(1'b1);
        rd_chk("R5 status error", 8'h93, 8'd3);
        rd_chk("R5 count kept", 8'h94, 8'd1);
    endtask

    task automatic t_tx_badlen;
        wr(8'h10, 8'd0);
        wr(8'h11, 8'd1);
        rd_chk("R4 length 0 error", 8'h93, 8'd3);
        rd_chk("R4 length 0 count", 8'h94, 8'd0);
        chk("R4 length 0 no byte", {7'd0, tx_valid}, 8'd0);
        wr(8'h10, 8'd17);
        wr(8'h11, 8'd1);
        rd_chk("R4 length 17 error", 8'h93, 8'd3);
        chk("R4 length 17 no byte", {7'd0, tx_valid}, 8'd0);
        wr(8'h10, 8'd16);
        wr(8'h11, 8'd1);
        rd_chk("R3 length 16 accepted", 8'h93, 8'd1);
        wr(8'h11, 8'd2);
        chk("R7 abort drops valid", {7'd0, tx_valid}, 8'd0);
        rd_chk("R7 abort status", 8'h93, 8'd0);
        rd_chk("R7 abort count", 8'h94, 8'd0);
    endtask

    task automatic t_tx_clear;
        wr(8'h13, 8'd0);
        rd_chk("R8 byte 0 cleared", 8'h00, 8'd0);
        rd_chk("R8 byte 3 cleared", 8'h03, 8'd0);
        rd_chk("R8 length cleared", 8'h10, 8'd0);
        rd_chk("R8 status cleared", 8'h93, 8'd0);
    endtask

    task automatic t_rx_queue;
        rd_chk("R9 empty length", 8'h90, 8'd0);
        rx_frame(3, 8'h40, 1'b0, 1'b1);
        rd_chk("R9 status done", 8'h91, 8'd2);
        rd_chk("R9 count one", 8'h92, 8'd1);
        rd_chk("R9 length", 8'h90, 8'd3);
        rd_chk("R9 byte 0", 8'h80, 8'h40);
        rd_chk("R9 byte 2", 8'h82, 8'h42);
        rx_frame(2, 8'h50, 1'b0, 1'b0);
        rd_chk("R10 count two", 8'h92, 8'd2);
        rd_chk("R10 head still first", 8'h80, 8'h40);
        rx_frame(3, 8'h60, 1'b0, 1'b0);
        rd_chk("R11 full drop status", 8'h91, 8'd3);
        rd_chk("R11 full drop count", 8'h92, 8'd2);
        rd_chk("R11 full head intact", 8'h81, 8'h41);
        wr(8'h14, 8'd3);
        rd_chk("R10 pop count", 8'h92, 8'd1);
        rd_chk("R10 pop status idle", 8'h91, 8'd0);
        rd_chk("R10 second frame length", 8'h90, 8'd2);
        rd_chk("R10 second frame byte 1", 8'h81, 8'h51);
        rx_frame(2, 8'h70, 1'b1, 1'b0);
        rd_chk("R11 error frame status", 8'h91, 8'd3);
        rd_chk("R11 error frame count", 8'h92, 8'd1);
        rx_frame(17, 8'h00, 1'b0, 1'b0);
        rd_chk("R11 long frame status", 8'h91, 8'd3);
        rd_chk("R11 long frame count", 8'h92, 8'd1);
    endtask

    task automatic t_rx_disable;
        wr(8'h14, 8'd2);
        rd_chk("R12 disable status", 8'h91, 8'd0);
        rx_frame(2, 8'h90, 1'b0, 1'b0);
        rd_chk("R12 disabled count", 8'h92, 8'd1);
        rd_chk("R12 disabled status", 8'h91, 8'd0);
        wr(8'h14, 8'd1);
        rx_frame(1, 8'hC0, 1'b0, 1'b0);
        rd_chk("R12 re-enabled count", 8'h92, 8'd2);
    endtask

    task automatic t_rx_clear;
        wr(8'h15, 8'd0);
        rd_chk("R13 count cleared", 8'h92, 8'd0);
        rd_chk("R13 status cleared", 8'h91, 8'd0);
        rd_chk("R13 length reads 0", 8'h90, 8'd0);
        rx_frame(1, 8'hE0, 1'b0, 1'b0);
        rd_chk("R13 reception enabled", 8'h92, 8'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_regs();
        t_tx_send_ok();
        t_tx_send_err();
        t_tx_badlen();
        t_tx_clear();
        t_rx_queue();
        t_rx_disable();
        t_rx_clear();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule